// File: doc/BRIEF.md
# Serial Baud Rate Generator

This block produces the bit timing for one serial channel. A bus write loads an 8-bit divide value `n`. The bus clock first passes through a prescaler, which divides it by 1, 4, 16 or 64. A down-counter then divides the prescaled tick rate by `n+1`. What happens after that depends on the channel mode.

- **Synchronous mode, internal clock:** a toggle stage halves the counter output. The result drives the serial clock pin and a shift enable.
- **Asynchronous (UART) mode:** the counter output is a 16x sample tick. A divide-by-16 stage turns it into the bit-rate shift enable.
- **Synchronous mode, external clock:** the counter is bypassed. The block synchronises the incoming serial clock and emits one shift enable per falling edge.

A divide value written while the channel runs does not take effect at once. It is picked up only when the running count reaches zero. While the channel enable is low, the counter holds in reload and all pulses stop. The divide register has no defined contents after reset, so software must write it before enabling the channel. The model clears it to zero.

Top module: `baud_gen`

## Requirements
- R1: After reset, `shift_en` and `sample_tick` are 0 and `sclk_out` is 1.
- R2: `presc_sel` values 0, 1, 2 and 3 select a prescale factor P of 1, 4, 16 and 64 bus clocks. The counter completes once every (n+1)*P bus clocks, where n is the programmed divide value.
- R3: In mode 2'b00 (synchronous, internal clock), `sclk_out` toggles at each count completion, so its period is 2*(n+1)*P. `shift_en` pulses in the same cycle that `sclk_out` falls, once per period.
- R4: In mode 2'b10 or 2'b11 (UART), `sample_tick` pulses once per count completion. `shift_en` pulses once every 16 sample ticks, in a cycle that also carries a sample tick. `sample_tick` stays 0 in the other modes.
- R5: In mode 2'b01 (synchronous, external clock), `shift_en` pulses exactly once for each falling edge of `ext_sclk`, independent of the divide value. `sclk_out` stays 1.
- R6: A divide value written while the channel runs first applies to the count that starts after the current count completes.
- R7: While `xfer_en` is 0, no `shift_en` or `sample_tick` pulse occurs and `sclk_out` is 1. Counting starts fresh when `xfer_en` rises. Counting the first cycle that samples `xfer_en` high as cycle 1, the first count completion is visible in cycle (n+1)*P.
- R8: `shift_en` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| div_wr | input | 1 | Write strobe for the divide value |
| div_wdata | input | 8 | Divide value n |
| mode | input | 2 | 00 synchronous internal, 01 synchronous external, 1x UART |
| presc_sel | input | 2 | Prescale select (1, 4, 16, 64) |
| xfer_en | input | 1 | Channel transmit/receive enable |
| ext_sclk | input | 1 | External serial clock |
| shift_en | output | 1 | One-cycle shift enable |
| sample_tick | output | 1 | One-cycle 16x sample enable (UART) |
| sclk_out | output | 1 | Serial clock output, idles high |

## Verification
The checker module tests properties on every cycle:

- the single-cycle width of `shift_en`;
- silence and a high `sclk_out` while the channel is disabled;
- no sample ticks outside UART mode;
- each UART shift landing on a sample tick;
- each internal serial-clock fall coinciding with a shift.

Only the bench's scenarios can show the cycle counts themselves. These are the (n+1)*P periods across prescale settings, the start-up latency after enable, the delayed adoption of a divide value written mid-run, and the one-to-one mapping of external clock edges to shifts.

// File: rtl/baud_pkg.sv
package baud_pkg;
    typedef enum logic [1:0] {
        MODE_SYNC_INT = 2'b00,
        MODE_SYNC_EXT = 2'b01,
        MODE_ASYNC    = 2'b10,
        MODE_ASYNC_ALT = 2'b11
    } baud_mode_e;

    function automatic logic is_async(input logic [1:0] m);
        return m[1];
    endfunction
endpackage

// File: rtl/baud_presc.sv
module baud_presc #(
    parameter int SEL_W = 2,
    parameter int STEP  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CW = STEP * ((1 << SEL_W) - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [CW:0]   lim_wide;
    logic [CW-1:0] lim;

    always_comb begin
        lim_wide = ((CW+1)'(1) << (32'(sel) * STEP)) - (CW+1)'(1);
        lim      = lim_wide[CW-1:0];
        tick     = en && (st_q.cnt == lim);
        st_d     = st_q;
        if (!en || tick) st_d.cnt = '0;
        else             st_d.cnt = st_q.cnt + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/baud_count.sv
module baud_count #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [DIV_W-1:0] reload,
    output logic             done
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        done = en && tick && (st_q.cnt == '0);
        st_d = st_q;
        if (!en)                 st_d.cnt = reload;
        else if (done)           st_d.cnt = reload;
        else if (tick)           st_d.cnt = st_q.cnt - DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/baud_post.sv
module baud_post
    import baud_pkg::*;
#(
    parameter int OVS  = 16,
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] mode,
    input  logic       done,
    input  logic       ext_sclk,
    output logic       shift_en,
    output logic       sample_tick,
    output logic       sclk_out
);
    localparam int OW = $clog2(OVS);

    typedef struct packed {
        logic            sclk;
        logic [OW-1:0]   sub;
        logic [SYNC-1:0] sync;
        logic            prev;
        logic            shift;
        logic            samp;
    } st_t;

    st_t  st_d, st_q;
    logic ext_fall;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC-2:0], ext_sclk};
        st_d.prev = st_q.sync[SYNC-1];
        ext_fall  = st_q.prev && !st_q.sync[SYNC-1];
        st_d.shift = 1'b0;
        st_d.samp  = 1'b0;
        if (!en) begin
            st_d.sclk = 1'b1;
            st_d.sub  = '0;
        end else if (is_async(mode)) begin
            st_d.samp = done;
            if (done) begin
                st_d.sub   = st_q.sub + OW'(1);
                st_d.shift = (st_q.sub == OW'(OVS - 1));
            end
        end else if (mode == MODE_SYNC_INT) begin
            if (done) begin
                st_d.sclk  = !st_q.sclk;
                st_d.shift = st_q.sclk;
            end
        end else begin
            st_d.shift = ext_fall;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.sclk <= 1'b1;
            st_q.sync <= '1;
            st_q.prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign shift_en    = st_q.shift;
    assign sample_tick = st_q.samp;
    assign sclk_out    = (mode == MODE_SYNC_INT) ? st_q.sclk : 1'b1;
endmodule

// File: rtl/baud_gen.sv
module baud_gen #(
    parameter int DIV_W = 8,
    parameter int SEL_W = 2,
    parameter int STEP  = 2,
    parameter int OVS   = 16,
    parameter int SYNC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic [1:0]       mode,
    input  logic [SEL_W-1:0] presc_sel,
    input  logic             xfer_en,
    input  logic             ext_sclk,
    output logic             shift_en,
    output logic             sample_tick,
    output logic             sclk_out
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
    } st_t;

    st_t  st_d, st_q;
    logic tick, done;

    always_comb begin
        st_d = st_q;
        if (div_wr) st_d.div = div_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    baud_presc #(.SEL_W(SEL_W), .STEP(STEP)) u_presc (
        .clk(clk), .rst_n(rst_n), .en(xfer_en), .sel(presc_sel), .tick(tick)
    );

    baud_count #(.DIV_W(DIV_W)) u_count (
        .clk(clk), .rst_n(rst_n), .en(xfer_en), .tick(tick),
        .reload(st_q.div), .done(done)
    );

    baud_post #(.OVS(OVS), .SYNC(SYNC)) u_post (
        .clk(clk), .rst_n(rst_n), .en(xfer_en), .mode(mode), .done(done),
        .ext_sclk(ext_sclk), .shift_en(shift_en), .sample_tick(sample_tick),
        .sclk_out(sclk_out)
    );
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       xfer_en,
    input logic       shift_en,
    input logic       sample_tick,
    input logic       sclk_out
);
    p_single_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> !shift_en);

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_en |=> (!shift_en && !sample_tick && sclk_out));

    p_tick_async_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mode[1] |=> !sample_tick);

    p_shift_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && shift_en) |-> sample_tick);

    p_fall_with_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && $past(mode) == 2'b00 && xfer_en && $past(xfer_en)
         && $fell(sclk_out)) |-> shift_en);
endmodule

bind baud_gen baud_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .xfer_en(xfer_en),
    .shift_en(shift_en), .sample_tick(sample_tick), .sclk_out(sclk_out)
);

// File: tb/sim_baud_gen.sv
`timescale 1ns/1ps
module sim_baud_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div_wr = 1'b0;
    logic [7:0] div_wdata = '0;
    logic [1:0] mode = 2'b00;
    logic [1:0] presc_sel = 2'b00;
    logic       xfer_en = 1'b0;
    logic       ext_sclk = 1'b1;
    logic       shift_en, sample_tick, sclk_out;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    baud_gen u0 (
        .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_wdata(div_wdata),
        .mode(mode), .presc_sel(presc_sel), .xfer_en(xfer_en), .ext_sclk(ext_sclk),
        .shift_en(shift_en), .sample_tick(sample_tick), .sclk_out(sclk_out)
    );

    function automatic int pf(input int sel);
        return 1 << (2 * sel);
    endfunction

    function automatic int exp_shift(input int m, input int sel, input int n);
        if (m >= 2) return 16 * (n + 1) * pf(sel);
        return 2 * (n + 1) * pf(sel);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // cycles until chosen output (0 shift_en, 1 sample_tick) is high
    task automatic wait_pulse(input int which, input int limit, output int cyc);
        cyc = 0;
        do begin
            @(posedge clk); #1; cyc++;
        end while (!((which == 0) ? shift_en : sample_tick) && cyc < limit);
    endtask

    task automatic setup(input int m, input int sel, input int n);
        @(posedge clk); #1;
        xfer_en = 1'b0;
        div_wr = 1'b1; div_wdata = 8'(n);
        @(posedge clk); #1;
        div_wr = 1'b0;
        mode = 2'(m); presc_sel = 2'(sel);
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic run_cfg(input int m, input int sel, input int n);
        int c, e, tog;
        logic prev;
        setup(m, sel, n);
        xfer_en = 1'b1;
        // R7 start latency: first count completion in cycle (n+1)*P
        if (m >= 2) begin
            wait_pulse(1, 100000, c);
            check(c == (n + 1) * pf(sel), "R7 first sample_tick latency", c, (n + 1) * pf(sel));
            wait_pulse(1, 100000, c);
            check(c == (n + 1) * pf(sel), "R2 sample_tick period", c, (n + 1) * pf(sel));
            wait_pulse(0, 100000, c);
        end else begin
            wait_pulse(0, 100000, c);
            check(c == (n + 1) * pf(sel), "R7 first shift latency", c, (n + 1) * pf(sel));
        end
        e = exp_shift(m, sel, n);
        for (int k = 0; k < 2; k++) begin
            tog = 0; c = 0; prev = sclk_out;
            do begin
                @(posedge clk); #1; c++;
                if (sclk_out != prev) tog++;
                prev = sclk_out;
            end while (!shift_en && c < 100000);
            check(c == e, (m >= 2) ? "R4 shift period" : "R3 shift period", c, e);
            if (m == 0) check(tog == 2, "R3 sclk toggles per period", tog, 2);
            else        check(sclk_out == 1'b1, "R4 sclk idle in UART", sclk_out, 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int c, n, s, m, cnt;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        check(shift_en == 1'b0, "R1 shift_en in reset", shift_en, 0);
        check(sample_tick == 1'b0, "R1 sample_tick in reset", sample_tick, 0);
        check(sclk_out == 1'b1, "R1 sclk_out in reset", sclk_out, 1);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(shift_en == 1'b0 && sclk_out == 1'b1, "R1 after release", sclk_out, 1);

        // directed: fastest internal clock, period 2 bus clocks
        run_cfg(0, 0, 0);
        // directed: every prescale setting (R2)
        for (int k = 0; k < 4; k++) run_cfg(0, k, 1);
        run_cfg(2, 0, 0);
        run_cfg(3, 1, 2);

        // random configurations
        for (int t = 0; t < 10; t++) begin
            m = ($urandom % 2 == 0) ? 0 : 2;
            n = $urandom % 8;
            s = (m == 2) ? $urandom % 3 : $urandom % 4;
            run_cfg(m, s, n);
        end

        // R7: disabled channel stays quiet
        setup(0, 0, 0);
        cnt = 0;
        for (int k = 0; k < 50; k++) begin
            @(posedge clk); #1;
            if (shift_en || sample_tick || !sclk_out) cnt++;
        end
        check(cnt == 0, "R7 no activity while disabled", cnt, 0);

        // R6: mid-run write applies after current count
        setup(2, 0, 5);
        xfer_en = 1'b1;
        wait_pulse(1, 1000, c);
        div_wr = 1'b1; div_wdata = 8'd2;
        @(posedge clk); #1; div_wr = 1'b0;
        c = 1;
        while (!sample_tick && c < 1000) begin @(posedge clk); #1; c++; end
        check(c == 6, "R6 old value finishes", c, 6);
        wait_pulse(1, 1000, c);
        check(c == 3, "R6 new value applied", c, 3);
        wait_pulse(1, 1000, c);
        check(c == 3, "R6 new value persists", c, 3);

        // R5: external clock, counter bypassed; R8 single-cycle pulses
        setup(1, 3, 200);
        xfer_en = 1'b1;
        cnt = 0;
        for (int e = 0; e < 7; e++) begin
            for (int k = 0; k < 12; k++) begin
                @(posedge clk); #1;
                if (shift_en) cnt++;
                if (k == 5) ext_sclk = ~ext_sclk;
                check(sclk_out == 1'b1, "R5 sclk_out high in external mode", sclk_out, 1);
            end
        end
        repeat (6) begin @(posedge clk); #1; if (shift_en) cnt++; end
        // ext_sclk starts high, 7 toggles -> 4 falling edges
        check(cnt == 4, "R5 one shift per external falling edge", cnt, 4);
        xfer_en = 1'b0;

        // R8: shift_en single-cycle at fastest rate
        setup(0, 0, 0);
        xfer_en = 1'b1;
        cnt = 0;
        begin
            logic p;
            p = 1'b0;
            for (int k = 0; k < 40; k++) begin
                @(posedge clk); #1;
                if (p && shift_en) cnt++;
                p = shift_en;
            end
        end
        check(cnt == 0, "R8 no back-to-back shift_en", cnt, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule